// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable model of a byte-wide nonvolatile memory that a bus master reaches over a two-wire serial bus. The array holds 8192 bytes by default. A fast system clock oversamples the bus clock and data lines. The block drives the data line open-drain: it only ever pulls the line low, through an output-enable signal. Three strap inputs set the low bits of its bus address, so several copies can share one bus. A write-inhibit input protects the array.

A transaction opens with a START and a select byte. A write command carries two address bytes, high byte first, and then up to one page of data bytes. These bytes are gathered in a page buffer and copied into the array after the closing STOP, during a fixed-length internal write period. The slave ignores the bus while that period runs. A read command returns bytes from an internal address pointer. The master can first aim that pointer with a write-mode select and address followed by a repeated START, or it can read on from wherever the pointer already stands. The pointer advances after every byte the slave sends.

A synchronous reset stands in for power-on reset. Input filtering and electrical timing are not modelled.

Top module: `tw_eeprom`

## Requirements
- R1: The slave answers only a select byte whose seven upper bits, sent MSB first, are 1,0,1,0 followed by the strap values for bits 2, 1 and 0; bit 0 of the byte is the direction (1 = read). Any other select byte gets no acknowledge and the slave goes quiet until the next START.
- R2: For every byte the slave accepts, it holds SDA low (output enable high) for the whole ninth clock.
- R3: Before a START, and after it stops decoding, the slave releases SDA and acknowledges nothing.
- R4: A write of one data byte takes effect at the closing STOP, and the byte then reads back at its address.
- R5: During a page write, the low 5 address bits wrap inside the 32-byte page; the upper bits stay fixed.
- R6: A random read (write-mode select, two address bytes, repeated START, read-mode select) returns the byte at that address.
- R7: A write command that stops before any data byte starts no write period. It only loads the pointer, and a following current-address read returns the byte there and then the next one.
- R8: Sequential reads return consecutive addresses while the master acknowledges, wrap from 8191 to 0, and end on a master no-acknowledge.
- R9: With the write-inhibit input high, the select and address bytes are acknowledged, data bytes are not, and the array is unchanged.
- R10: For WR_CYCLES system clocks after a STOP that closes a write holding data, the slave ignores the bus, then answers again.
- R11: The top 3 bits of the first address byte are ignored.
- R12: During and right after reset the output enable is low.
- R13: The output enable changes only while the synchronized SCL is low, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe_o | output | 1 | High pulls the data line low |
| chip_en_i | input | 3 | Address straps, compared with select bits 3..1 |
| wr_inhibit_i | input | 1 | High refuses data bytes of write commands |

## Verification
Embedded properties check on every cycle that the data line is released while the slave is idle or busy, that it is held low through each acknowledge, that it changes only while the bus clock is low, and that a data byte arriving with writes inhibited is never acknowledged. Only the directed scenarios can show what ends up in the array: page wrap, the commit at STOP, pointer loading by an address-only write, read wrap at the top address, and how long the slave stays silent after a write.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    // Fixed upper nibble of the select byte
    localparam logic [3:0] SEL_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RX   = 3'd1,
        ST_ACK  = 3'd2,
        ST_TX   = 3'd3,
        ST_MACK = 3'd4,
        ST_BUSY = 3'd5
    } ctrl_state_e;

    typedef enum logic [1:0] {
        PH_SEL  = 2'd0,
        PH_AHI  = 2'd1,
        PH_ALO  = 2'd2,
        PH_DATA = 2'd3
    } rx_phase_e;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES = 2;
    localparam int HIST  = STAGES + 1;

    logic [LINES-1:0]           raw;
    logic [LINES-1:0][HIST-1:0] pipe_d, pipe_q;
    logic [LINES-1:0]           cur, prv;

    assign raw = {sda_i, scl_i};

    // Each line: STAGES synchronizer flops plus one history flop
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign pipe_d[i] = {pipe_q[i][HIST-2:0], raw[i]};
        assign cur[i]    = pipe_q[i][STAGES-1];
        assign prv[i]    = pipe_q[i][STAGES];
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= pipe_d;
    end

    assign scl_lvl_o  = cur[0];
    assign sda_lvl_o  = cur[1];
    assign scl_rise_o = cur[0] & ~prv[0];
    assign scl_fall_o = ~cur[0] & prv[0];
    assign start_o    = cur[0] & prv[0] & prv[1] & ~cur[1];
    assign stop_o     = cur[0] & prv[0] & ~prv[1] & cur[1];

endmodule

// File: rtl/tw_eeprom_store.sv
module tw_eeprom_store #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/tw_eeprom_ctrl.sv
module tw_eeprom_ctrl
    import tw_eeprom_pkg::*;
#(
    parameter int AW        = 13,
    parameter int PAGE      = 32,
    parameter int WR_CYCLES = 2000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_lvl_i,
    input  logic          sda_lvl_i,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [2:0]    chip_en_i,
    input  logic          wc_i,
    input  logic [7:0]    rdata_i,
    output logic [AW-1:0] raddr_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic          sda_oe_o
);
    localparam int PW  = $clog2(PAGE);
    localparam int CW  = $clog2(WR_CYCLES + 1);
    localparam int HIW = AW - 8;

    typedef struct packed {
        ctrl_state_e          st;
        rx_phase_e            ph;
        logic [3:0]           bitcnt;
        logic [7:0]           shreg;
        logic                 rw;
        logic                 oe;
        logic                 mack;
        logic [AW-1:0]        addr;
        logic [AW-PW-1:0]     page;
        logic [PAGE-1:0][7:0] pbuf;
        logic [PAGE-1:0]      valid;
        logic [CW-1:0]        busy_cnt;
    } ctrl_t;

    ctrl_t q, n;
    logic [AW-1:0] full_addr;

    always_comb begin
        n         = q;
        we_o      = 1'b0;
        full_addr = {q.addr[AW-1:8], q.shreg};

        if (q.st == ST_BUSY) begin
            // Internal write period: commit one buffered byte per clock
            if (int'(q.busy_cnt) < PAGE && q.valid[q.busy_cnt[PW-1:0]]) we_o = 1'b1;
            if (q.busy_cnt == CW'(WR_CYCLES - 1)) begin
                n.st       = ST_IDLE;
                n.valid    = '0;
                n.busy_cnt = '0;
            end else begin
                n.busy_cnt = q.busy_cnt + 1'b1;
            end
        end else if (start_i) begin
            n.st     = ST_RX;
            n.ph     = PH_SEL;
            n.bitcnt = '0;
            n.oe     = 1'b0;
            n.valid  = '0;
        end else if (stop_i) begin
            n.oe     = 1'b0;
            n.bitcnt = '0;
            if (|q.valid) begin
                n.st       = ST_BUSY;
                n.busy_cnt = '0;
            end else begin
                n.st = ST_IDLE;
            end
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise_i && q.bitcnt != 4'd8) begin
                        n.shreg  = {q.shreg[6:0], sda_lvl_i};
                        n.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall_i && q.bitcnt == 4'd8) begin
                        n.bitcnt = '0;
                        unique case (q.ph)
                            PH_SEL: begin
                                if (q.shreg[7:1] == {SEL_CODE, chip_en_i}) begin
                                    n.rw = q.shreg[0];
                                    n.st = ST_ACK;
                                    n.oe = 1'b1;
                                    n.ph = q.shreg[0] ? PH_DATA : PH_AHI;
                                end else begin
                                    n.st = ST_IDLE;
                                end
                            end
                            PH_AHI: begin
                                n.addr[AW-1:8] = q.shreg[HIW-1:0];
                                n.st           = ST_ACK;
                                n.oe           = 1'b1;
                                n.ph           = PH_ALO;
                            end
                            PH_ALO: begin
                                n.addr  = full_addr;
                                n.page  = full_addr[AW-1:PW];
                                n.valid = '0;
                                n.st    = ST_ACK;
                                n.oe    = 1'b1;
                                n.ph    = PH_DATA;
                            end
                            default: begin
                                if (wc_i) begin
                                    n.st = ST_IDLE;
                                end else begin
                                    n.pbuf[q.addr[PW-1:0]]  = q.shreg;
                                    n.valid[q.addr[PW-1:0]] = 1'b1;
                                    n.addr[PW-1:0]          = q.addr[PW-1:0] + 1'b1;
                                    n.st                    = ST_ACK;
                                    n.oe                    = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        n.bitcnt = '0;
                        if (q.rw) begin
                            n.st    = ST_TX;
                            n.shreg = rdata_i;
                            n.oe    = ~rdata_i[7];
                        end else begin
                            n.st = ST_RX;
                            n.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (q.bitcnt == 4'd7) begin
                            n.st   = ST_MACK;
                            n.oe   = 1'b0;
                            n.mack = 1'b0;
                            n.addr = q.addr + 1'b1;
                        end else begin
                            n.shreg  = {q.shreg[6:0], 1'b0};
                            n.bitcnt = q.bitcnt + 4'd1;
                            n.oe     = ~q.shreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        n.mack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            n.st     = ST_TX;
                            n.bitcnt = '0;
                            n.shreg  = rdata_i;
                            n.oe     = ~rdata_i[7];
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign raddr_o  = q.addr;
    assign waddr_o  = {q.page, q.busy_cnt[PW-1:0]};
    assign wdata_o  = q.pbuf[q.busy_cnt[PW-1:0]];
    assign sda_oe_o = q.oe;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE) |-> !q.oe); // R3
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_BUSY) |-> !q.oe); // R10
    AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_ACK) |-> q.oe); // R2
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(q.oe) |-> $past(!scl_lvl_i || start_i || stop_i)); // R13
    AST_INHIBIT_NACK: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_RX && q.ph == PH_DATA && !q.rw && scl_fall_i &&
         q.bitcnt == 4'd8 && wc_i && !start_i && !stop_i) |=> !q.oe); // R9
    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        q.bitcnt <= 4'd8); // R2

endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom #(
    parameter int AW        = 13,
    parameter int PAGE      = 32,
    parameter int WR_CYCLES = 2000,
    parameter int SYNC      = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] chip_en_i,
    input  logic       wr_inhibit_i
);
    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic          we;
    logic [AW-1:0] raddr, waddr;
    logic [7:0]    wdata, rdata;

    tw_line_sync #(.STAGES(SYNC)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    tw_eeprom_ctrl #(.AW(AW), .PAGE(PAGE), .WR_CYCLES(WR_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .scl_lvl_i  (scl_lvl),
        .sda_lvl_i  (sda_lvl),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .chip_en_i  (chip_en_i),
        .wc_i       (wr_inhibit_i),
        .rdata_i    (rdata),
        .raddr_o    (raddr),
        .we_o       (we),
        .waddr_o    (waddr),
        .wdata_o    (wdata),
        .sda_oe_o   (sda_oe_o)
    );

    tw_eeprom_store #(.AW(AW)) u_store (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

endmodule

// File: tb/sim_tw_eeprom.sv
module sim_tw_eeprom;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WRC        = 2000;
    localparam int WATCHDOG   = 190000;
    localparam logic [7:0] SEL_W = 8'hAA;
    localparam logic [7:0] SEL_R = 8'hAB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wc = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [2:0] straps = 3'b101;

    int checks = 0;
    int fails  = 0;
    int r13_bad = 0;
    logic prev_oe = 1'b0;
    bit finished = 0;
    logic [7:0] rd [4];

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_eeprom #(.AW(13), .PAGE(32), .WR_CYCLES(WRC)) u0 (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (m_scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .chip_en_i    (straps),
        .wr_inhibit_i (wc)
    );

    // R13 monitor: drive must not change while the bus clock is high
    always @(posedge clk) begin
        #1;
        if (!rst && sda_oe != prev_oe && m_scl) r13_bad++;
        prev_oe = sda_oe;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_restart();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait(); qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qwait();
            m_scl = 1'b1; qwait(); qwait();
            m_scl = 1'b0;
        end
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        ack = !sda_line; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            qwait();
            m_scl = 1'b1; qwait();
            b = {b[6:0], sda_line}; qwait();
            m_scl = 1'b0;
        end
        m_sda = !give_ack; qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
        m_sda = 1'b1;
    endtask

    task automatic wait_write();
        repeat (WRC + 50) @(negedge clk);
    endtask

    // Random read of n bytes into rd[]; acks checked against tag
    task automatic random_read(input string tag, input logic [15:0] a, input int cnt);
        bit ack;
        bus_start();
        send_byte(SEL_W, ack); check({tag, " sel ack"}, ack, 1);
        send_byte(a[15:8], ack); check({tag, " ahi ack"}, ack, 1);
        send_byte(a[7:0], ack);  check({tag, " alo ack"}, ack, 1);
        bus_restart();
        send_byte(SEL_R, ack); check({tag, " rd sel ack"}, ack, 1);
        for (int i = 0; i < cnt; i++) recv_byte(i != cnt - 1, rd[i]);
        bus_stop();
    endtask

    task automatic write_one(input logic [15:0] a, input logic [7:0] d);
        bit ack;
        bus_start();
        send_byte(SEL_W, ack);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        send_byte(d, ack);
        bus_stop();
        wait_write();
    endtask

    task automatic t_reset();
        check("R12 oe during reset", int'(sda_oe), 0);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R12 oe after reset", int'(sda_oe), 0);
    endtask

    task automatic t_select();
        bit ack;
        bus_start(); send_byte(8'hA0, ack); bus_stop();
        check("R1 wrong straps nack", ack, 0);
        bus_start(); send_byte(8'hBA, ack); bus_stop();
        check("R1 wrong device code nack", ack, 0);
        bus_start(); send_byte(SEL_W, ack);
        check("R1 R2 matching select ack", ack, 1);
        bus_stop();
    endtask

    task automatic t_no_start();
        bit ack;
        send_byte(SEL_W, ack);
        check("R3 no ack without START", ack, 0);
        check("R3 released", int'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic t_byte_write_busy();
        bit ack;
        bus_start();
        send_byte(SEL_W, ack); check("R2 sel ack", ack, 1);
        send_byte(8'h01, ack); check("R2 addr hi ack", ack, 1);
        send_byte(8'h23, ack); check("R2 addr lo ack", ack, 1);
        send_byte(8'hA5, ack); check("R2 data ack", ack, 1);
        bus_stop();
        bus_start(); send_byte(SEL_W, ack); bus_stop();
        check("R10 no ack during write period", ack, 0);
        wait_write();
        bus_start(); send_byte(SEL_W, ack); bus_stop();
        check("R10 ack after write period", ack, 1);
        random_read("R6", 16'h0123, 1);
        check("R4 R6 byte write readback", rd[0], 8'hA5);
    endtask

    task automatic t_page();
        bit ack;
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        bus_start();
        send_byte(SEL_W, ack);
        send_byte(8'h00, ack);
        send_byte(8'h5E, ack);
        for (int i = 0; i < 4; i++) begin
            send_byte(d[i], ack);
            check("R5 page data ack", ack, 1);
        end
        bus_stop();
        wait_write();
        random_read("R5", 16'h0040, 2);
        check("R5 wrapped byte at 0x40", rd[0], 8'h33);
        check("R5 wrapped byte at 0x41", rd[1], 8'h44);
        random_read("R8", 16'h005E, 2);
        check("R8 sequential 0x5E", rd[0], 8'h11);
        check("R8 sequential 0x5F", rd[1], 8'h22);
    endtask

    task automatic t_addr_only();
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(SEL_W, ack);
        send_byte(8'h00, ack);
        send_byte(8'h40, ack);
        bus_stop();
        bus_start(); send_byte(SEL_R, ack);
        check("R7 no write period after address-only", ack, 1);
        recv_byte(1'b0, b); bus_stop();
        check("R7 current read at loaded pointer", b, 8'h33);
        bus_start(); send_byte(SEL_R, ack);
        recv_byte(1'b0, b); bus_stop();
        check("R7 current read advanced", b, 8'h44);
    endtask

    task automatic t_upper_bits();
        random_read("R11", 16'hE123, 1);
        check("R11 upper address bits ignored", rd[0], 8'hA5);
    endtask

    task automatic t_inhibit();
        bit ack;
        wc = 1'b1;
        bus_start();
        send_byte(SEL_W, ack); check("R9 sel ack when inhibited", ack, 1);
        send_byte(8'h01, ack); check("R9 addr hi ack when inhibited", ack, 1);
        send_byte(8'h23, ack); check("R9 addr lo ack when inhibited", ack, 1);
        send_byte(8'h5A, ack); check("R9 data nack when inhibited", ack, 0);
        bus_stop();
        wc = 1'b0;
        random_read("R9", 16'h0123, 1);
        check("R9 memory unchanged", rd[0], 8'hA5);
    endtask

    task automatic t_wrap();
        write_one(16'h1FFF, 8'h77);
        write_one(16'h0000, 8'h88);
        random_read("R8", 16'h1FFF, 2);
        check("R8 top address", rd[0], 8'h77);
        check("R8 wrap to zero", rd[1], 8'h88);
    endtask

    initial begin
        t_reset();
        t_select();
        t_no_start();
        t_byte_write_busy();
        t_page();
        t_addr_only();
        t_upper_bits();
        t_inhibit();
        t_wrap();
        check("R13 drive changes only with SCL low", r13_bad, 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule